// File: doc/BRIEF.md
# Sprite Attribute Page Copier with CPU Lock-Out

This block copies a 160-byte page from anywhere in the CPU address space into sprite attribute memory, one byte per step. Software starts a copy by supplying the high byte of the source address; the low byte is always zero. Each step reads one byte through a source read port and writes it through an attribute-memory write port. The first step comes after a fixed lead-in, and the rest follow at a fixed pace.

While a copy is in flight, the block also guards the CPU. It watches the CPU address and raises a blocked flag when that address falls in a region the copy is using. A blocked read returns 0xFF, and a blocked write is suppressed. The region always includes the attribute memory window. It also includes a second window that depends on which 8 KB page the source lies in. A select input chooses between two variant tables for that second window.

The source read port is assumed to return data in the same cycle the address is presented. The block's own source reads are never subject to the blocking check.

Top module: `oam_copy_engine`

## Requirements
- R1: A start request whose high byte is greater than 0xF1 (base address above 0xF100) is ignored. It does not start a copy, it does not change the timing of a copy in flight, and it does not move that copy's source or destination.
- R2: A start request with a high byte of 0xF1 or less is accepted at the clock edge where it is sampled. After that edge, `busy` is 1, the source is {high,0x00}, the destination index is 0, and 160 bytes remain.
- R3: The first write (`oamWrEn` high) occupies the 8th clock cycle after the accepting edge. Each following write comes exactly 4 cycles after the previous one.
- R4: Write number i (0 to 159) presents `srcAddr` = base+i, `oamAddr` = i and `oamData` = `srcData`. `busy` falls at the edge that ends write 159.
- R5: While `busy` is 1, any CPU address from 0xFE00 to 0xFE9F is blocked.
- R6: With `altMap`=0 and `busy`=1, the source page is srcAddr[15:13]:
  - page 4 blocks 0x8000–0x9FFF;
  - any other page blocks 0xA000–0xFDFF.
- R7: With `altMap`=1 and `busy`=1:
  - page 4 blocks 0x8000–0x9FFF;
  - page 6 blocks 0xC000–0xFDFF;
  - any other page blocks 0xA000–0xBFFF.
- R8: A valid start request during a copy discards the pending step, even when it falls in a write cycle. It then restarts with the new base and the full 8-cycle lead-in.
- R9: A blocked access makes `cpuRdOut` 0xFF and `cpuWrOut` 0. An unblocked access passes `cpuRdIn` and `cpuWrEn` through unchanged, and nothing is blocked while `busy` is 0.
- R10: Synchronous active-high `rst` clears busy, count, source and destination, and no write occurs during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| altMap | input | 1 | Selects the second conflict table (R7) |
| startReq | input | 1 | Start strobe |
| startHigh | input | 8 | High byte of the source base |
| busy | output | 1 | Copy in flight |
| srcRdEn | output | 1 | Source read strobe |
| srcAddr | output | 16 | Source read address |
| srcData | input | 8 | Source read data, same cycle |
| oamWrEn | output | 1 | Attribute memory write strobe |
| oamAddr | output | 8 | Attribute memory byte index |
| oamData | output | 8 | Attribute memory write data |
| cpuAddr | input | 16 | Current CPU access address |
| cpuRdIn | input | 8 | Read data from the CPU-side decoder |
| cpuRdOut | output | 8 | Read data after blocking |
| cpuWrEn | input | 1 | CPU write strobe |
| cpuWrOut | output | 1 | CPU write strobe after blocking |
| cpuBlock | output | 1 | Current CPU access is blocked |

## Verification
The hardest case is a restart whose request lands in the exact cycle of a pending write. The write strobe must vanish in that cycle, and the lead-in must start over. The bench reaches this by counting falling edges from the accepting edge and raising the new request on the eighth one. A second hard case is an out-of-range request arriving mid-lead-in, which must leave the schedule untouched; the bench injects it one cycle after a valid start. The page-dependent windows are reached by restarting with chosen high bytes under each table, probing both sides of every boundary.

// File: rtl/oam_dma_pkg.sv
package oam_dma_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } dmaStrobe_t;

  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/oam_dma_ctrl.sv
module oam_dma_ctrl
  import oam_dma_pkg::*;
#(
  parameter int LEN = 160,
  parameter int LEAD = 8,
  parameter int GAP = 4,
  parameter logic [7:0] HI_LIMIT = 8'hF1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       startReq,
  input  logic [7:0] startHigh,
  output dmaStrobe_t strb,
  output logic       busy
);
  localparam int CNT_W = $clog2(LEN + 1);
  localparam int MAXW  = (LEAD > GAP) ? LEAD : GAP;
  localparam int TMR_W = $clog2(MAXW);

  logic [CNT_W-1:0] count;
  logic [TMR_W-1:0] timer;
  logic startOk;

  assign startOk   = startReq && (startHigh <= HI_LIMIT);
  assign busy      = (count != '0);
  assign strb.load = startOk;
  assign strb.step = busy && (timer == '0) && !startOk;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      timer <= '0;
    end else if (strb.load) begin
      count <= CNT_W'(LEN);
      timer <= TMR_W'(LEAD - 1);
    end else if (strb.step) begin
      count <= count - 1'b1;
      timer <= TMR_W'(GAP - 1);
    end else if (busy && timer != '0) begin
      timer <= timer - 1'b1;
    end
  end

  AST_BAD_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    (startReq && startHigh > HI_LIMIT && !busy) |=> !busy); // R1
  AST_LEAD_IN_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(strb.load) |-> !strb.step); // R3
  AST_STEP_SPACING: assert property (@(posedge clk) disable iff (rst)
    $past(strb.step) |-> !strb.step); // R3
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> busy); // R2
endmodule

// File: rtl/oam_dma_path.sv
module oam_dma_path
  import oam_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  dmaStrobe_t        strb,
  input  logic [7:0]        startHigh,
  input  logic [BYTE_W-1:0] srcData,
  output logic              srcRdEn,
  output logic [ADDR_W-1:0] srcAddr,
  output logic              oamWrEn,
  output logic [7:0]        oamAddr,
  output logic [BYTE_W-1:0] oamData
);
  logic [ADDR_W-1:0] source;
  logic [7:0]        dest;

  always_ff @(posedge clk) begin
    if (rst) begin
      source <= '0;
      dest   <= '0;
    end else if (strb.load) begin
      source <= {startHigh, 8'h00};
      dest   <= '0;
    end else if (strb.step) begin
      source <= source + 1'b1;
      dest   <= dest + 1'b1;
    end
  end

  assign srcRdEn = strb.step;
  assign srcAddr = source;
  assign oamWrEn = strb.step;
  assign oamAddr = dest;
  assign oamData = srcData;

  AST_LOAD_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    $past(strb.load) |-> (oamAddr == 8'h00 && srcAddr[7:0] == 8'h00)); // R2
  AST_DEST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    ($past(strb.step) && !$past(rst)) |-> (oamAddr == $past(oamAddr) + 8'h01)); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!strb.load && !strb.step) |=> $stable(srcAddr)); // R1
endmodule

// File: rtl/oam_conflict_map.sv
module oam_conflict_map
  import oam_dma_pkg::*;
#(
  parameter logic [ADDR_W-1:0] OAM_LO = 16'hFE00,
  parameter logic [ADDR_W-1:0] OAM_HI = 16'hFEA0
) (
  input  logic              altMap,
  input  logic              busy,
  input  logic [2:0]        srcPage,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] VID_LO  = 16'h8000;
  localparam logic [ADDR_W-1:0] EXT_LO  = 16'hA000;
  localparam logic [ADDR_W-1:0] WORK_LO = 16'hC000;
  localparam logic [ADDR_W-1:0] TOP_HI  = 16'hFE00;

  logic [ADDR_W-1:0] winLo, winHi;
  logic inOam, inWin;

  always_comb begin
    if (srcPage == 3'd4) begin
      winLo = VID_LO;
      winHi = EXT_LO;
    end else if (!altMap) begin
      winLo = EXT_LO;
      winHi = TOP_HI;
    end else if (srcPage == 3'd6) begin
      winLo = WORK_LO;
      winHi = TOP_HI;
    end else begin
      winLo = EXT_LO;
      winHi = WORK_LO;
    end
  end

  assign inOam = (cpuAddr >= OAM_LO) && (cpuAddr < OAM_HI);
  assign inWin = (cpuAddr >= winLo) && (cpuAddr < winHi);
  assign hit   = busy && (inOam || inWin);
endmodule

// File: rtl/oam_copy_engine.sv
module oam_copy_engine
  import oam_dma_pkg::*;
#(
  parameter int LEN = 160,
  parameter int LEAD = 8,
  parameter int GAP = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        altMap,
  input  logic        startReq,
  input  logic [7:0]  startHigh,
  output logic        busy,
  output logic        srcRdEn,
  output logic [15:0] srcAddr,
  input  logic [7:0]  srcData,
  output logic        oamWrEn,
  output logic [7:0]  oamAddr,
  output logic [7:0]  oamData,
  input  logic [15:0] cpuAddr,
  input  logic [7:0]  cpuRdIn,
  output logic [7:0]  cpuRdOut,
  input  logic        cpuWrEn,
  output logic        cpuWrOut,
  output logic        cpuBlock
);
  dmaStrobe_t strb;

  oam_dma_ctrl #(.LEN(LEN), .LEAD(LEAD), .GAP(GAP)) ctrl_i (
    .clk(clk), .rst(rst), .startReq(startReq), .startHigh(startHigh),
    .strb(strb), .busy(busy)
  );

  oam_dma_path path_i (
    .clk(clk), .rst(rst), .strb(strb), .startHigh(startHigh),
    .srcData(srcData), .srcRdEn(srcRdEn), .srcAddr(srcAddr),
    .oamWrEn(oamWrEn), .oamAddr(oamAddr), .oamData(oamData)
  );

  oam_conflict_map map_i (
    .altMap(altMap), .busy(busy), .srcPage(srcAddr[15:13]),
    .cpuAddr(cpuAddr), .hit(cpuBlock)
  );

  assign cpuRdOut = cpuBlock ? 8'hFF : cpuRdIn;
  assign cpuWrOut = cpuWrEn && !cpuBlock;

  AST_OAM_GUARD: assert property (@(posedge clk) disable iff (rst)
    (busy && cpuAddr >= 16'hFE00 && cpuAddr <= 16'hFE9F) |-> cpuBlock); // R5
  AST_IDLE_OPEN: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cpuBlock); // R9
  AST_BLOCK_EFFECT: assert property (@(posedge clk) disable iff (rst)
    cpuBlock |-> (!cpuWrOut && cpuRdOut == 8'hFF)); // R9
  AST_NO_WRITE_IN_RESET: assert property (@(posedge clk)
    $past(rst) |-> !busy); // R10
endmodule

// File: tb/oam_copy_engine_tb.sv
module oam_copy_engine_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic altMap = 1'b0;
  logic startReq = 1'b0;
  logic [7:0] startHigh = 8'h00;
  logic busy, srcRdEn, oamWrEn, cpuWrOut, cpuBlock;
  logic [15:0] srcAddr;
  logic [7:0] srcData, oamAddr, oamData, cpuRdOut;
  logic [15:0] cpuAddr = 16'h0000;
  logic [7:0] cpuRdIn = 8'h5A;
  logic cpuWrEn = 1'b1;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  assign srcData = srcAddr[15:8] ^ srcAddr[7:0] ^ 8'h3C;

  oam_copy_engine dut_i (
    .clk(clk), .rst(rst), .altMap(altMap), .startReq(startReq),
    .startHigh(startHigh), .busy(busy), .srcRdEn(srcRdEn), .srcAddr(srcAddr),
    .srcData(srcData), .oamWrEn(oamWrEn), .oamAddr(oamAddr), .oamData(oamData),
    .cpuAddr(cpuAddr), .cpuRdIn(cpuRdIn), .cpuRdOut(cpuRdOut),
    .cpuWrEn(cpuWrEn), .cpuWrOut(cpuWrOut), .cpuBlock(cpuBlock)
  );

  // {altMap, startHigh, cpuAddr, expected block}
  localparam int NVEC = 26;
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b0, 8'h80, 16'h8000, 1'b1}, {1'b0, 8'h80, 16'h9FFF, 1'b1},
    {1'b0, 8'h80, 16'hA000, 1'b0}, {1'b0, 8'h80, 16'hFE00, 1'b1},
    {1'b0, 8'h80, 16'hC000, 1'b0}, {1'b0, 8'hC0, 16'hA000, 1'b1},
    {1'b0, 8'hC0, 16'hFDFF, 1'b1}, {1'b0, 8'hC0, 16'h9FFF, 1'b0},
    {1'b0, 8'hC0, 16'hFE9F, 1'b1}, {1'b0, 8'hC0, 16'hFEA0, 1'b0},
    {1'b0, 8'hC0, 16'hFF80, 1'b0}, {1'b0, 8'h00, 16'hC123, 1'b1},
    {1'b1, 8'h80, 16'h8000, 1'b1}, {1'b1, 8'h80, 16'hA000, 1'b0},
    {1'b1, 8'hC0, 16'hC000, 1'b1}, {1'b1, 8'hC0, 16'hFDFF, 1'b1},
    {1'b1, 8'hC0, 16'hBFFF, 1'b0}, {1'b1, 8'hC0, 16'hFE50, 1'b1},
    {1'b1, 8'h00, 16'hA000, 1'b1}, {1'b1, 8'h00, 16'hBFFF, 1'b1},
    {1'b1, 8'h00, 16'hC000, 1'b0}, {1'b1, 8'h00, 16'h8000, 1'b0},
    {1'b1, 8'hE0, 16'hA000, 1'b1}, {1'b1, 8'hE0, 16'hE000, 1'b0},
    {1'b1, 8'hF1, 16'hFE00, 1'b1}, {1'b1, 8'hF1, 16'hFEA0, 1'b0}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the accepting edge
  task automatic startDma(input logic [7:0] hi);
    startReq = 1'b1;
    startHigh = hi;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  // counts falling edges (current one = n0) until a write is seen
  task automatic waitWrite(input int n0, output int n);
    n = n0;
    while (!oamWrEn && n < 64) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic logic [7:0] expData(input logic [15:0] a);
    return a[15:8] ^ a[7:0] ^ 8'h3C;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    int n;
    int wr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cpuAddr = 16'hFE00;
    #1;
    check(busy == 1'b0, "R10 busy after reset", busy, 0);
    check(cpuBlock == 1'b0, "R9 idle no block", cpuBlock, 0);
    check(cpuRdOut == 8'h5A && cpuWrOut == 1'b1, "R9 idle pass-through",
          {cpuRdOut, 7'd0, cpuWrOut}, {8'h5A, 8'h01});

    // R1: invalid start from idle
    @(negedge clk);
    startDma(8'hF2);
    repeat (10) begin
      check(!busy && !oamWrEn, "R1 invalid start from idle", {busy, oamWrEn}, 0);
      @(negedge clk);
    end

    // R2, R3, R4: full transfer
    startDma(8'hC1);
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    check(srcAddr == 16'hC100 && oamAddr == 8'h00, "R2 origin",
          {srcAddr, oamAddr}, {16'hC100, 8'h00});
    n = 1;
    wr = 0;
    for (int guard = 0; guard < 1000; guard++) begin
      if (oamWrEn) begin
        check(n == 8 + 4 * wr, "R3 write timing", n, 8 + 4 * wr);
        check(oamAddr == wr[7:0] && srcAddr == 16'hC100 + wr[15:0] &&
              oamData == expData(16'hC100 + wr[15:0]) && srcRdEn,
              "R4 write fields", {srcAddr, oamAddr, oamData},
              {16'hC100 + wr[15:0], wr[7:0], expData(16'hC100 + wr[15:0])});
        wr++;
      end
      if (wr == 160) break;
      @(negedge clk);
      n++;
    end
    check(wr == 160, "R4 byte count", wr, 160);
    @(negedge clk);
    check(busy == 1'b0, "R4 idle after last byte", busy, 0);

    // R1: invalid start during lead-in changes nothing
    startDma(8'hC0);
    startReq = 1'b1;
    startHigh = 8'hF5;
    @(negedge clk);
    startReq = 1'b0;
    waitWrite(2, n);
    check(n == 8, "R1 schedule kept", n, 8);
    check(srcAddr == 16'hC000 && oamAddr == 8'h00, "R1 source kept",
          srcAddr, 16'hC000);

    // R8: restart mid lead-in
    @(negedge clk);
    startDma(8'hC0);
    repeat (4) @(negedge clk);
    startDma(8'hD0);
    waitWrite(1, n);
    check(n == 8, "R8 restart lead-in", n, 8);
    check(srcAddr == 16'hD000 && oamAddr == 8'h00, "R8 restart base",
          srcAddr, 16'hD000);

    // R8: restart exactly on a write cycle
    @(negedge clk);
    startDma(8'hC0);
    repeat (7) @(negedge clk);
    check(oamWrEn == 1'b1, "R3 write at cycle 8", oamWrEn, 1);
    startReq = 1'b1;
    startHigh = 8'h90;
    #1;
    check(oamWrEn == 1'b0, "R8 pending step cancelled", oamWrEn, 0);
    @(negedge clk);
    startReq = 1'b0;
    waitWrite(1, n);
    check(n == 8 && srcAddr == 16'h9000 && oamAddr == 8'h00, "R8 restart on step",
          {n[15:0], srcAddr}, {16'd8, 16'h9000});

    // R5, R6, R7, R9: conflict table
    @(negedge clk);
    for (int i = 0; i < NVEC; i++) begin
      altMap = VEC[i][25];
      startDma(VEC[i][24:17]);
      cpuAddr = VEC[i][16:1];
      #1;
      check(cpuBlock == VEC[i][0], VEC[i][25] ? "R7 table B block" : "R6 table A block",
            cpuBlock, VEC[i][0]);
      check(cpuRdOut == (VEC[i][0] ? 8'hFF : 8'h5A), "R9 read data", cpuRdOut,
            VEC[i][0] ? 8'hFF : 8'h5A);
      check(cpuWrOut == !VEC[i][0], "R9 write strobe", cpuWrOut, !VEC[i][0]);
    end

    // R5: attribute window boundaries under table A, source page 6
    altMap = 1'b0;
    startDma(8'hC0);
    cpuAddr = 16'hFE9F;
    #1;
    check(cpuBlock == 1'b1, "R5 last OAM byte", cpuBlock, 1);
    cpuAddr = 16'hFEA0;
    #1;
    check(cpuBlock == 1'b0, "R5 past OAM window", cpuBlock, 0);

    // R10: reset mid transfer
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && oamWrEn == 1'b0, "R10 reset clears", {busy, oamWrEn}, 0);
    rst = 1'b0;
    cpuAddr = 16'hFE10;
    repeat (12) begin
      @(negedge clk);
      check(!oamWrEn && !cpuBlock, "R10 stays idle", {oamWrEn, cpuBlock}, 0);
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule